// File: doc/BRIEF.md
# Direct-Page Bit Test and Modify Sequencer

This block carries out single-bit instructions that work on one byte of the zero page, the first 256 bytes of a 16-bit address space. The opcode itself selects both the bit and the operation. One opcode group tests a memory bit, copies that bit into the carry flag and takes a relative branch when the bit has the wanted value. The other group forces the bit to one or to zero with a read-modify-write access that leaves the other seven bits as they were.

The surrounding core has already fetched the opcode, the direct address byte and, for a test instruction, the displacement. It hands these over with the address of the opcode and the current carry flag, and raises a start strobe for one cycle. The block then drives a simple byte memory port through a fixed series of steps. It returns the next program counter and the resulting carry flag, and marks the last cycle of the instruction with a one-cycle done pulse. A start strobe is accepted only while the sequencer is idle.

Top module: `dp_bitop_seq`

## Requirements
- R1: Only opcodes 0x00 to 0x1F are executed. A start strobe with any other opcode is ignored: no memory strobe, no done pulse, and carry_o and next_pc_o keep their values.
- R2: Every memory access uses address {0x00, direct byte}. The upper eight address bits are always zero.
- R3: For opcodes 0x00 to 0x0F the tested bit index is opcode[3:1]. An even opcode branches when that bit is 1, and an odd opcode branches when it is 0.
- R4: A taken test branch gives next_pc = opcode address + 3 + sign-extended 8-bit displacement, modulo 2^16. A branch that is not taken gives opcode address + 3.
- R5: A test instruction places the tested bit on carry_o and never asserts mem_wr_o.
- R6: A test instruction takes 5 cycles. The start cycle is cycle 1 and done_o is high in cycle 5. Exactly one read occurs, in cycle 2.
- R7: For opcodes 0x10 to 0x1F, an even opcode sets bit opcode[3:1] of the byte and an odd opcode clears it. The byte is read once and written back once. The other seven bits are unchanged.
- R8: A set or clear instruction takes 4 cycles, with done_o high in cycle 4. It gives next_pc = opcode address + 2, modulo 2^16. carry_o equals the carry_i sampled with the start strobe.
- R9: done_o is high for exactly one cycle per accepted instruction. A start strobe that arrives while an instruction is in progress is ignored.
- R10: After reset done_o, mem_rd_o and mem_wr_o are low and carry_o and next_pc_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to run the presented instruction |
| opcode_i | input | 8 | Instruction opcode |
| dir_addr_i | input | 8 | Direct (zero-page) address byte |
| disp_i | input | 8 | Signed branch displacement (test instructions only) |
| pc_i | input | 16 | Address of the opcode byte |
| carry_i | input | 1 | Carry flag value before the instruction |
| mem_addr_o | output | 16 | Memory byte address |
| mem_rd_o | output | 1 | Read strobe; data is taken from mem_rdata_i in the same cycle |
| mem_rdata_i | input | 8 | Read data |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| carry_o | output | 1 | Carry flag after the instruction |
| next_pc_o | output | 16 | Next program counter, valid while done_o is high |
| done_o | output | 1 | One-cycle pulse in the last cycle of an instruction |

## Verification
The bench runs all 32 executable opcodes against two complementary bytes, 0x5A and 0xA5. With these bytes every bit index is seen both at 1 and at 0, so a wrong bit index or a reversed branch sense gives a visibly different carry, next PC or write-back byte. Further cases use a negative displacement, a program counter that wraps past 0xFFFF, and a set or clear of a bit that already holds the target value, where the written byte must equal the byte that was read. Opcodes outside the executed range and a second start strobe inside a running instruction check that nothing moves: no strobe, no extra done pulse, and unchanged outputs.

// File: rtl/dp_bitop_pkg.sv
package dp_bitop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TEST,
        ST_RESOLVE,
        ST_WRITE,
        ST_FINISH
    } seq_state_e;

    // Decoded instruction fields
    typedef struct packed {
        logic       valid;      // opcode in the executed group
        logic       is_branch;  // test-and-branch group
        logic       polarity;   // branch-on-one / set (1), branch-on-zero / clear (0)
        logic [2:0] bit_idx;    // selected bit of the operand byte
    } op_dec_t;

endpackage

// File: rtl/dp_bitop_decode.sv
module dp_bitop_decode
    import dp_bitop_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic [OP_W-1:0] opcode,
    output op_dec_t         dec
);

    always_comb begin
        dec           = '0;
        dec.valid     = (opcode[OP_W-1:5] == '0);
        dec.is_branch = ~opcode[4];
        dec.polarity  = ~opcode[0];
        dec.bit_idx   = opcode[3:1];
    end

endmodule

// File: rtl/dp_bitop_bitunit.sv
module dp_bitop_bitunit #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [IDX_W-1:0]  idx,
    input  logic              new_val,
    output logic              picked,
    output logic [DATA_W-1:0] modified
);

    assign picked = data[idx];

    // One lane per bit: only the addressed lane takes the new value
    for (genvar g = 0; g < DATA_W; g++) begin : g_lane
        assign modified[g] = (idx == IDX_W'(g)) ? new_val : data[g];
    end

endmodule

// File: rtl/dp_bitop_pcgen.sv
module dp_bitop_pcgen #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8
) (
    input  logic [PC_W-1:0]   base_pc,
    input  logic [DISP_W-1:0] disp,
    input  logic              is_branch,
    input  logic              taken,
    output logic [PC_W-1:0]   next_pc
);

    localparam logic [PC_W-1:0] LEN_TEST   = PC_W'(3);
    localparam logic [PC_W-1:0] LEN_MODIFY = PC_W'(2);

    logic [PC_W-1:0] disp_ext;
    logic [PC_W-1:0] step;

    always_comb begin
        disp_ext = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};
        step     = is_branch ? LEN_TEST : LEN_MODIFY;
        next_pc  = base_pc + step + ((is_branch && taken) ? disp_ext : '0);
    end

endmodule

// File: rtl/dp_bitop_seq.sv
module dp_bitop_seq
    import dp_bitop_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PC_W   = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        opcode_i,
    input  logic [7:0]        dir_addr_i,
    input  logic [7:0]        disp_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic              carry_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              mem_wr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              carry_o,
    output logic [PC_W-1:0]   next_pc_o,
    output logic              done_o
);

    localparam int PAGE_W = 8;
    localparam int DISP_W = 8;

    typedef struct packed {
        seq_state_e        state;
        op_dec_t           dec;
        logic [PAGE_W-1:0] addr;
        logic [DISP_W-1:0] disp;
        logic [PC_W-1:0]   pc;
        logic [DATA_W-1:0] data;
        logic              carry;
        logic              taken;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    op_dec_t           dec_in;
    logic              bit_val;
    logic [DATA_W-1:0] byte_mod;
    logic [PC_W-1:0]   pc_calc;

    dp_bitop_decode #(.OP_W(8)) u_decode (
        .opcode (opcode_i),
        .dec    (dec_in)
    );

    dp_bitop_bitunit #(.DATA_W(DATA_W)) u_bitunit (
        .data     (seq_q.data),
        .idx      (seq_q.dec.bit_idx),
        .new_val  (seq_q.dec.polarity),
        .picked   (bit_val),
        .modified (byte_mod)
    );

    dp_bitop_pcgen #(.PC_W(PC_W), .DISP_W(DISP_W)) u_pcgen (
        .base_pc   (seq_q.pc),
        .disp      (seq_q.disp),
        .is_branch (seq_q.dec.is_branch),
        .taken     (seq_q.taken),
        .next_pc   (pc_calc)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (start_i && dec_in.valid) begin
                    seq_d.state = ST_READ;
                    seq_d.dec   = dec_in;
                    seq_d.addr  = dir_addr_i;
                    seq_d.disp  = disp_i;
                    seq_d.pc    = pc_i;
                    seq_d.carry = carry_i;
                    seq_d.taken = 1'b0;
                end
            end
            ST_READ: begin
                seq_d.data  = mem_rdata_i;
                seq_d.state = seq_q.dec.is_branch ? ST_TEST : ST_WRITE;
            end
            ST_TEST: begin
                seq_d.carry = bit_val;
                seq_d.taken = (bit_val == seq_q.dec.polarity);
                seq_d.state = ST_RESOLVE;
            end
            ST_RESOLVE: begin
                seq_d.pc    = pc_calc;
                seq_d.state = ST_FINISH;
            end
            ST_WRITE: begin
                seq_d.pc    = pc_calc;
                seq_d.state = ST_FINISH;
            end
            ST_FINISH: begin
                seq_d.state = ST_IDLE;
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mem_addr_o  = {{(ADDR_W-PAGE_W){1'b0}}, seq_q.addr};
    assign mem_rd_o    = (seq_q.state == ST_READ);
    assign mem_wr_o    = (seq_q.state == ST_WRITE);
    assign mem_wdata_o = byte_mod;
    assign carry_o     = seq_q.carry;
    assign next_pc_o   = seq_q.pc;
    assign done_o      = (seq_q.state == ST_FINISH);

    // R2: strobed accesses stay in the zero page
    assert_page_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o) |-> (mem_addr_o[ADDR_W-1:PAGE_W] == '0));

    // R5: a test instruction never writes
    assert_branch_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state != ST_IDLE && seq_q.dec.is_branch) |-> !mem_wr_o);

    // R7: write-back differs from the byte read in at most one bit
    assert_single_bit_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> ($countones(mem_wdata_o ^ seq_q.data) <= 1));

    // R9: done is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R1: an opcode outside the executed group starts nothing
    assert_ignore_invalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_IDLE && start_i && opcode_i[7:5] != 3'b000) |=> !mem_rd_o);

    // R6: an accepted start is followed directly by the read
    assert_read_follows_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_IDLE && start_i && opcode_i[7:5] == 3'b000) |=> mem_rd_o);

    // R6 R8: read and write never overlap
    assert_rd_wr_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

endmodule

// File: tb/dp_bitop_seq_bench.sv
module dp_bitop_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  opcode_i = '0;
    logic [7:0]  dir_addr_i = '0;
    logic [7:0]  disp_i = '0;
    logic [15:0] pc_i = '0;
    logic        carry_i = 1'b0;
    logic [15:0] mem_addr_o;
    logic        mem_rd_o;
    logic [7:0]  mem_rdata_i;
    logic        mem_wr_o;
    logic [7:0]  mem_wdata_o;
    logic        carry_o;
    logic [15:0] next_pc_o;
    logic        done_o;

    always #10 clk = ~clk;   // 50 MHz

    dp_bitop_seq u_dp_bitop_seq (
        .clk, .rst_n, .start_i, .opcode_i, .dir_addr_i, .disp_i, .pc_i, .carry_i,
        .mem_addr_o, .mem_rd_o, .mem_rdata_i, .mem_wr_o, .mem_wdata_o,
        .carry_o, .next_pc_o, .done_o
    );

    // Byte memory model with a preset path for the driver
    logic [7:0] mem [256];
    logic       pre_en = 1'b0;
    logic [7:0] pre_addr = '0;
    logic [7:0] pre_val = '0;

    assign mem_rdata_i = mem[mem_addr_o[7:0]];

    initial for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);

    always @(posedge clk) begin
        if (mem_wr_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
        else if (pre_en) mem[pre_addr] <= pre_val;
    end

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          done_cyc;
        logic [15:0] pc;
        logic        c;
        logic [7:0]  addr;
        logic [7:0]  byte_val;
        int          writes;
        bit          branch;
    } exp_t;

    exp_t sb[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: count strobes, compare on each done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd_o) rd_cnt++;
            if (mem_wr_o) wr_cnt++;
            if ((mem_rd_o || mem_wr_o) && mem_addr_o[15:8] != 8'h00)
                check(0, "R2", "address high byte", mem_addr_o, {8'h00, mem_addr_o[7:0]});
            if (done_o) begin
                if (sb.size() == 0) begin
                    check(0, "R9", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(cyc == e.done_cyc, e.branch ? "R6" : "R8", "done cycle", cyc, e.done_cyc);
                    check(next_pc_o == e.pc, e.branch ? "R4" : "R8", "next pc", next_pc_o, e.pc);
                    check(carry_o == e.c, e.branch ? "R5" : "R8", "carry", carry_o, e.c);
                    check(mem[e.addr] == e.byte_val, e.branch ? "R5" : "R7", "memory byte",
                          mem[e.addr], e.byte_val);
                    check(wr_cnt == e.writes, e.branch ? "R5" : "R7", "write count", wr_cnt, e.writes);
                    check(rd_cnt == 1, e.branch ? "R6" : "R7", "read count", rd_cnt, 1);
                end
                rd_cnt = 0;
                wr_cnt = 0;
            end
        end
    end

    task automatic poke(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        pre_en = 1'b1; pre_addr = a; pre_val = v;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    // Driver: compute the expected result, push it, issue the start strobe
    task automatic run_op(input logic [7:0] op, input logic [7:0] dir, input logic [7:0] disp,
                          input logic [15:0] pc, input logic cin, input bit busy_poke);
        exp_t e;
        logic [2:0] idx;
        logic b, tk;
        idx = op[3:1];
        b = mem[dir][idx];
        e.addr = dir;
        e.branch = (op[4] == 1'b0);
        e.byte_val = mem[dir];
        if (e.branch) begin
            tk = op[0] ? !b : b;
            e.pc = pc + 16'd3 + (tk ? {{8{disp[7]}}, disp} : 16'd0);
            e.c = b;
            e.writes = 0;
        end else begin
            e.byte_val[idx] = !op[0];
            e.pc = pc + 16'd2;
            e.c = cin;
            e.writes = 1;
        end
        @(negedge clk);
        opcode_i = op; dir_addr_i = dir; disp_i = disp; pc_i = pc; carry_i = cin;
        start_i = 1'b1;
        e.done_cyc = cyc + (e.branch ? 4 : 3);
        sb.push_back(e);
        @(negedge clk);
        if (busy_poke) begin
            opcode_i = 8'h1F; dir_addr_i = dir ^ 8'h01; pc_i = 16'h5555; carry_i = !cin;
        end else begin
            start_i = 1'b0;
        end
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(done_o == 0 && mem_rd_o == 0 && mem_wr_o == 0, "R10", "strobes in reset",
              {done_o, mem_rd_o, mem_wr_o}, 0);
        check(carry_o == 0 && next_pc_o == 0, "R10", "outputs in reset", {carry_o, next_pc_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(done_o == 0 && mem_rd_o == 0 && mem_wr_o == 0, "R10", "idle after reset",
              {done_o, mem_rd_o, mem_wr_o}, 0);

        // R3 R7: every executed opcode against two complementary patterns
        for (int p = 0; p < 2; p++) begin
            for (int op = 0; op < 32; op++) begin
                poke(8'h40, p == 0 ? 8'h5A : 8'hA5);
                run_op(8'(op), 8'h40, 8'h10, 16'h1000, op[1], 1'b0);
            end
        end

        // R4: negative displacement, taken branch on clear bit 7
        poke(8'h80, 8'h25);
        run_op(8'h0F, 8'h80, 8'hF0, 16'h2000, 1'b1, 1'b0);
        // R4: wrap-around of the program counter
        poke(8'h81, 8'h01);
        run_op(8'h00, 8'h81, 8'h05, 16'hFFFE, 1'b0, 1'b0);
        // R8: wrap-around of the short form
        run_op(8'h10, 8'h81, 8'h00, 16'hFFFF, 1'b1, 1'b0);
        // R7: set an already set bit, clear an already clear bit, top address
        poke(8'hFF, 8'h80);
        run_op(8'h1E, 8'hFF, 8'h00, 16'h0300, 1'b0, 1'b0);
        poke(8'hFF, 8'h7F);
        run_op(8'h1F, 8'hFF, 8'h00, 16'h0300, 1'b1, 1'b0);

        // R9: second start inside a running instruction is ignored
        poke(8'h22, 8'h00);
        poke(8'h23, 8'hFF);
        run_op(8'h03, 8'h22, 8'h08, 16'h0400, 1'b1, 1'b1);
        check(mem[8'h23] == 8'hFF, "R9", "neighbour byte untouched", mem[8'h23], 8'hFF);
        run_op(8'h1A, 8'h22, 8'h00, 16'h0500, 1'b1, 1'b1);
        check(mem[8'h23] == 8'hFF, "R9", "neighbour byte after modify", mem[8'h23], 8'hFF);

        // R1: opcodes outside the executed group
        for (int k = 0; k < 3; k++) begin
            logic [15:0] pc_before;
            logic        c_before;
            pc_before = next_pc_o;
            c_before  = carry_o;
            @(negedge clk);
            opcode_i = (k == 0) ? 8'h20 : (k == 1) ? 8'hA5 : 8'hFF;
            dir_addr_i = 8'h22; pc_i = 16'h7777; carry_i = !c_before; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (6) @(negedge clk);
            check(rd_cnt == 0 && wr_cnt == 0, "R1", "strobes for ignored opcode",
                  rd_cnt + wr_cnt, 0);
            check(next_pc_o == pc_before && carry_o == c_before, "R1", "outputs for ignored opcode",
                  {carry_o, next_pc_o}, {c_before, pc_before});
        end

        check(sb.size() == 0, "R9", "pending expected items", sb.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule